// File: doc/BRIEF.md
# Dual-Half 64-bit Mailbox Queue

This block is a first-in, first-out message store for 64-bit mailbox entries. Entries come in on a one-cycle write strobe. A host whose data bus is only 32 bits wide reads them out through a small register window. One word offset of the window returns the lower half of the oldest stored entry. A second offset returns the upper half and also retires that entry. A host therefore reads the low word first and then the high word to consume one message.

Two level outputs go to the system. `notEmpty` is meant for an interrupt line. `full` shows that a further write would be lost. A write that arrives while the queue is full is discarded, and a sticky `overflow` bit records the loss until reset. The whole block runs on one clock. Read data is registered and appears in the cycle after the read strobe.

Top module: `mbox_queue`

## Requirements
- R1: After reset `rdData` is 0, and `notEmpty`, `full` and `overflow` are all 0.
- R2: A write (`wrValid` high) while the queue is not full is stored. Entries come out in the order they were written.
- R3: A read (`rdEn` high) at offset `LO_OFS` (default 0x4) while the queue holds an entry returns bits [31:0] of the oldest entry on `rdData` in the following cycle. It does not remove the entry.
- R4: A read at offset `HI_OFS` (default 0x8) while the queue holds an entry returns bits [63:32] of the oldest entry in the following cycle. The same clock edge removes that entry.
- R5: `notEmpty` is 1 exactly when at least one entry is stored. It reflects a write or removal from the cycle after the strobe.
- R6: `full` is 1 exactly when `DEPTH` entries (default 16, a power of two) are stored.
- R7: A write while `full` is 1 is dropped, even when a high-half read removes an entry in the same cycle. It sets `overflow`, which then stays 1 until reset.
- R8: A read of either half while the queue is empty returns 0 and leaves the queue unchanged.
- R9: A write and a high-half read in the same cycle on a non-empty, non-full queue both take effect, and the entry count is unchanged.
- R10: A read at any offset other than `LO_OFS` or `HI_OFS`, or any cycle with `rdEn` low, gives `rdData` = 0 in the following cycle and removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write strobe for one entry |
| wrData | input | 64 | Entry to store |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 4 | Byte offset within the mailbox window |
| rdData | output | 32 | Registered read data |
| notEmpty | output | 1 | At least one entry is stored |
| full | output | 1 | No room for another entry |
| overflow | output | 1 | Sticky flag: a write was dropped |

## Verification
The bench fills the queue to its last slot and checks that `full` rises only on the sixteenth write. It then writes into a full queue, both alone and together with a high-half read. A design that judged fullness after the removal would accept that write, and one that lost the overflow bit would show a clear flag afterwards. The bench repeats low-half reads and checks that the same word comes back each time, which catches a design that retires the entry on the wrong half. It runs simultaneous writes and removals for many cycles, across several pointer wraps. A wrap-bit error would raise `full` or `notEmpty` at the wrong time or return stale entries. Reads of the empty queue and reads at unused offsets must return zero and leave the next valid read unchanged.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic push;    // store wrData at the tail
    logic takeLo;  // register lower half of the head
    logic takeHi;  // register upper half of the head (head is retired)
  } mbox_strobe_t;

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int AW     = 4,
  parameter int LO_OFS = 4,
  parameter int HI_OFS = 8,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output mbox_strobe_t  strobe,
  output logic [PW-1:0] wrIdx,
  output logic [PW-1:0] rdIdx,
  output logic          notEmpty,
  output logic          full,
  output logic          overflow
);

  logic [PW:0] wrPtr;
  logic [PW:0] rdPtr;
  logic [PW:0] count;
  logic        hitLo;
  logic        hitHi;

  assign count    = wrPtr - rdPtr;
  assign notEmpty = (wrPtr != rdPtr);
  assign full     = (wrPtr[PW-1:0] == rdPtr[PW-1:0]) && (wrPtr[PW] != rdPtr[PW]);
  assign wrIdx    = wrPtr[PW-1:0];
  assign rdIdx    = rdPtr[PW-1:0];

  assign hitLo = rdEn && (rdAddr == AW'(LO_OFS));
  assign hitHi = rdEn && (rdAddr == AW'(HI_OFS));

  always_comb begin
    strobe.push   = wrValid && !full;
    strobe.takeLo = hitLo && notEmpty;
    strobe.takeHi = hitHi && notEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      overflow <= 1'b0;
    end else begin
      if (strobe.push)      wrPtr <= wrPtr + 1'b1;
      if (strobe.takeHi)    rdPtr <= rdPtr + 1'b1;
      if (wrValid && full)  overflow <= 1'b1;
    end
  end

  // R6/R5: a full queue is never reported empty
  a_r6_full_has_entries: assert property (@(posedge clk) disable iff (!rstN)
    full |-> notEmpty);

  // R7: dropped write leaves the tail where it was
  a_r7_drop_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && full) |=> $stable(wrPtr));

  // R7: overflow flag is sticky
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R3: a low-half read never retires the head
  a_r3_lo_no_pop: assert property (@(posedge clk) disable iff (!rstN)
    (hitLo && !hitHi) |=> $stable(rdPtr));

  // R8: reading an empty queue moves nothing on the read side
  a_r8_empty_read_still: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !notEmpty) |=> $stable(rdPtr));

  // R9: push plus pop keeps occupancy
  a_r9_pushpop_count: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && strobe.takeHi) |=> (count == $past(count)));

  // R6: occupancy never exceeds the depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= (PW+1)'(DEPTH));

endmodule

// File: rtl/mbox_data.sv
module mbox_data
  import mbox_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DW     = 64,
  localparam int PW    = $clog2(DEPTH),
  localparam int HW    = DW / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  mbox_strobe_t  strobe,
  input  logic [PW-1:0] wrIdx,
  input  logic [PW-1:0] rdIdx,
  input  logic [DW-1:0] wrData,
  output logic [HW-1:0] rdData
);

  logic [DW-1:0] store [DEPTH];
  logic [DW-1:0] headWord;

  assign headWord = store[rdIdx];

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdData <= '0;
    else if (strobe.takeHi) rdData <= headWord[DW-1:HW];
    else if (strobe.takeLo) rdData <= headWord[HW-1:0];
    else                    rdData <= '0;
  end

  // R10/R8: cycles without a qualified read leave zero on the bus
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.takeLo || strobe.takeHi) |=> (rdData == '0));

  // R3/R4: both halves are never selected at once
  a_r4_one_half: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.takeLo && strobe.takeHi));

endmodule

// File: rtl/mbox_queue.sv
module mbox_queue
  import mbox_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DW     = 64,
  parameter int AW     = 4,
  parameter int LO_OFS = 4,
  parameter int HI_OFS = 8,
  localparam int PW    = $clog2(DEPTH),
  localparam int HW    = DW / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic [HW-1:0] rdData,
  output logic          notEmpty,
  output logic          full,
  output logic          overflow
);

  mbox_strobe_t  strobe;
  logic [PW-1:0] wrIdx;
  logic [PW-1:0] rdIdx;

  mbox_ctrl #(
    .DEPTH(DEPTH), .AW(AW), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdEn(rdEn), .rdAddr(rdAddr),
    .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .notEmpty(notEmpty), .full(full), .overflow(overflow)
  );

  mbox_data #(
    .DEPTH(DEPTH), .DW(DW)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: tb/tb_mbox_queue.sv
`timescale 1ns/1ps
module tb_mbox_queue;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [63:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        notEmpty, full, overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] mq [DEPTH];
  int mHead = 0;
  int mCnt = 0;
  bit mOv = 0;

  always #2.5 clk = ~clk;

  mbox_queue dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .notEmpty(notEmpty), .full(full), .overflow(overflow)
  );

  function automatic logic [63:0] pat(input int i);
    return {32'hC0DE0000 + 32'(i), 32'h0000BEEF ^ (32'(i) * 32'h01010101)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive, clock, compare against queue model
  task automatic step(input logic w, input logic [63:0] d, input logic r,
                      input logic [3:0] a, input string tag);
    logic [31:0] expRd;
    bit doPush, doPop;
    expRd  = '0;
    doPop  = 0;
    doPush = w && (mCnt < DEPTH);
    if (r && mCnt > 0 && a == 4'h4) expRd = mq[mHead][31:0];
    if (r && mCnt > 0 && a == 4'h8) begin
      expRd = mq[mHead][63:32];
      doPop = 1;
    end
    if (w && mCnt == DEPTH) mOv = 1;
    @(negedge clk);
    wrValid = w; wrData = d; rdEn = r; rdAddr = a;
    @(posedge clk);
    #1;
    wrValid = 0; rdEn = 0;
    if (doPush) mq[(mHead + mCnt) % DEPTH] = d;
    if (doPop) begin
      mHead = (mHead + 1) % DEPTH;
      mCnt--;
    end
    if (doPush) mCnt++;
    chk({tag, " rdData"}, 64'(rdData), 64'(expRd));
    chk("R5 notEmpty", 64'(notEmpty), 64'(mCnt > 0));
    chk("R6 full", 64'(full), 64'(mCnt == DEPTH));
    chk("R7 overflow", 64'(overflow), 64'(mOv));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1: reset state
    chk("R1 rdData", 64'(rdData), 64'h0);
    chk("R1 notEmpty", 64'(notEmpty), 64'h0);
    chk("R1 full", 64'(full), 64'h0);
    chk("R1 overflow", 64'(overflow), 64'h0);

    // R8: empty reads of both halves
    step(0, '0, 1, 4'h4, "R8");
    step(0, '0, 1, 4'h8, "R8");

    // R2/R6: fill to the last slot
    for (int i = 0; i < DEPTH; i++) step(1, pat(i), 0, 4'h0, "R2");

    // R7: write into full queue alone, then with a removal
    step(1, 64'hDEAD_DEAD_DEAD_DEAD, 0, 4'h0, "R7");
    step(1, 64'hBAD0_BAD0_BAD0_BAD0, 1, 4'h8, "R7");

    // R3: repeated low reads return the same word
    step(0, '0, 1, 4'h4, "R3");
    step(0, '0, 1, 4'h4, "R3");
    // R10: unused offsets and idle strobe
    step(0, '0, 1, 4'h0, "R10");
    step(0, '0, 1, 4'hC, "R10");
    step(0, '0, 0, 4'h8, "R10");
    step(0, '0, 1, 4'h4, "R10");

    // R4/R2: drain in order, low then high
    while (mCnt > 0) begin
      step(0, '0, 1, 4'h4, "R3");
      step(0, '0, 1, 4'h8, "R4");
    end
    step(0, '0, 1, 4'h8, "R8");

    // R9: steady push plus pop across many wraps
    for (int i = 0; i < 3; i++) step(1, pat(100 + i), 0, 4'h0, "R2");
    for (int i = 0; i < 5 * DEPTH; i++) step(1, pat(200 + i), 1, 4'h8, "R9");

    // R9 at the empty edge: push with empty read
    while (mCnt > 0) step(0, '0, 1, 4'h8, "R4");
    step(1, pat(999), 1, 4'h8, "R8");
    step(0, '0, 1, 4'h4, "R3");
    step(0, '0, 1, 4'h8, "R4");

    // R9 at depth-1 occupancy: push and pop just below full
    for (int i = 0; i < DEPTH - 1; i++) step(1, pat(300 + i), 0, 4'h0, "R2");
    step(1, pat(400), 1, 4'h8, "R9");
    step(1, pat(401), 0, 4'h0, "R6");
    while (mCnt > 0) step(0, '0, 1, 4'h8, "R4");

    finishRun();
  end

endmodule